// File: doc/BRIEF.md
# Indirect Address Pointer Unit

This block holds two 16-bit pointer registers and uses them to read one byte indirectly into a working register. An operation names a pointer, then either a step mode or a signed offset. The step mode can adjust the pointer before the access or after it, by one in either direction. The offset form adds a small signed literal to the pointer to form the address and leaves the pointer as it was. The block never stores anything at the indirect location itself. Every access goes to data memory at the computed effective address.

A single `start` pulse launches an operation. In that cycle the effective address appears on `mem_addr` with `mem_rd` high. The memory answers one cycle later. On the following clock edge the block writes the byte to the working register, sets the zero flag from that byte and stores the new pointer value, all at once. It then raises `done` for one cycle. A host can load either pointer at any time through a separate load port. Pointer arithmetic wraps modulo 2^16, and no step of the pointer affects any flag.

Top module: `ptr_indirect_unit`

## Requirements
- R1: After reset both pointers, the working register, the zero flag, `busy` and `done` are all 0.
- R2: When `ld_en` is high at a clock edge, the pointer chosen by `ld_sel` (0 or 1) takes the value `ld_val`. The other pointer is not changed.
- R3: Mode code 00 (pre-increment), with `use_ofs` low: `mem_addr` is pointer+1 and the pointer becomes pointer+1.
- R4: Mode code 01 (pre-decrement): `mem_addr` is pointer−1 and the pointer becomes pointer−1.
- R5: Mode code 10 (post-increment): `mem_addr` is the unchanged pointer and the pointer becomes pointer+1.
- R6: Mode code 11 (post-decrement): `mem_addr` is the unchanged pointer and the pointer becomes pointer−1.
- R7: When `use_ofs` is high, `mem_addr` is the pointer plus `ofs_k` sign-extended from 6 bits (range −32 to +31). The pointer keeps its value.
- R8: All address and pointer arithmetic wraps modulo 2^16. For example, FFFFh+1 gives 0000h, and 0000h−1 gives FFFFh.
- R9: Two clock edges after `start` is accepted, `w_out` holds the byte that memory returned, `z_out` is 1 exactly when that byte is 0, and `done` is high for exactly one cycle.
- R10: An operation on one pointer leaves the other pointer unchanged. Neither pointer changes while the block is idle and no load is requested.
- R11: If a host load and an operation's commit target the same pointer at the same edge, the host load's value is kept.
- R12: A `start` that arrives while `busy` is high is ignored. It causes no extra memory read, no extra pointer step and no extra `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Launch an indirect read |
| sel | input | 1 | Pointer index for the operation |
| use_ofs | input | 1 | 1 selects offset addressing |
| mode | input | 2 | Step mode: 00 pre-inc, 01 pre-dec, 10 post-inc, 11 post-dec |
| ofs_k | input | 6 | Signed offset literal |
| ld_en | input | 1 | Host pointer load strobe |
| ld_sel | input | 1 | Pointer index for the host load |
| ld_val | input | 16 | Value for the host load |
| mem_addr | output | 16 | Effective address to data memory |
| mem_rd | output | 1 | Read request, high in the cycle `start` is accepted |
| mem_rdata | input | 8 | Memory read data, valid one cycle after `mem_rd` |
| w_out | output | 8 | Working register |
| z_out | output | 1 | Zero flag |
| ptr0 | output | 16 | Pointer 0 |
| ptr1 | output | 16 | Pointer 1 |
| busy | output | 1 | Operation waiting for memory data |
| done | output | 1 | One-cycle completion pulse |

## Verification
The assertions assume the memory returns data exactly one cycle after `mem_rd`, and that `start` is only meaningful when the block is idle. The stimulus holds `start` for one cycle per operation, except in the R12 case, where `start` is deliberately held into the busy cycle. Host loads change the pointers only at the times the bench model predicts, including the R11 load that collides with a commit. The memory model's contents are a function of the address that gives 0 at chosen addresses, so the zero flag is exercised in both states.

// File: rtl/ptr_indirect_unit.sv
module ptr_indirect_unit #(
  parameter int AW = 16,
  parameter int DW = 8,
  parameter int KW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          sel,
  input  logic          use_ofs,
  input  logic [1:0]    mode,
  input  logic [KW-1:0] ofs_k,
  input  logic          ld_en,
  input  logic          ld_sel,
  input  logic [AW-1:0] ld_val,
  output logic [AW-1:0] mem_addr,
  output logic          mem_rd,
  input  logic [DW-1:0] mem_rdata,
  output logic [DW-1:0] w_out,
  output logic          z_out,
  output logic [AW-1:0] ptr0,
  output logic [AW-1:0] ptr1,
  output logic          busy,
  output logic          done
);
  localparam logic [AW-1:0] ONE = AW'(1);

  logic          sel_q, upd_q;
  logic [AW-1:0] nxt_q, nxt, ea;
  logic          upd;

  wire [AW-1:0] cur = sel ? ptr1 : ptr0;
  wire [AW-1:0] kx  = {{(AW-KW){ofs_k[KW-1]}}, ofs_k};

  always_comb begin
    ea  = cur;
    nxt = cur;
    upd = 1'b0;
    if (use_ofs) begin
      ea = cur + kx;
    end else begin
      upd = 1'b1;
      case (mode)
        2'b00: begin ea = cur + ONE; nxt = cur + ONE; end
        2'b01: begin ea = cur - ONE; nxt = cur - ONE; end
        2'b10: nxt = cur + ONE;
        default: nxt = cur - ONE;
      endcase
    end
  end

  assign mem_addr = ea;
  assign mem_rd   = start & ~busy;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      done  <= 1'b0;
      sel_q <= 1'b0;
      upd_q <= 1'b0;
      nxt_q <= '0;
      w_out <= '0;
      z_out <= 1'b0;
    end else begin
      done <= busy;
      if (mem_rd) begin
        busy  <= 1'b1;
        sel_q <= sel;
        upd_q <= upd;
        nxt_q <= nxt;
      end else if (busy) begin
        busy  <= 1'b0;
        w_out <= mem_rdata;
        z_out <= (mem_rdata == '0);
      end
    end
  end

  wire commit = busy & upd_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr0 <= '0;
      ptr1 <= '0;
    end else begin
      if (ld_en && !ld_sel)            ptr0 <= ld_val;
      else if (commit && !sel_q)       ptr0 <= nxt_q;
      if (ld_en && ld_sel)             ptr1 <= ld_val;
      else if (commit && sel_q)        ptr1 <= nxt_q;
    end
  end
endmodule

module ptr_indirect_unit_chk #(
  parameter int AW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic          ld_en,
  input logic          mem_rd,
  input logic          busy,
  input logic          done,
  input logic [AW-1:0] ptr0,
  input logic [AW-1:0] ptr1
);
  AST_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> (busy && !done));  // R9
  AST_BUSY_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> (done && !busy));  // R9
  AST_DONE_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);  // R9
  AST_NO_RD_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !mem_rd);  // R12
  AST_PTR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !ld_en) |=> ($stable(ptr0) && $stable(ptr1)));  // R10
endmodule

bind ptr_indirect_unit ptr_indirect_unit_chk #(.AW(AW)) chk_i (
  .clk(clk), .rst_n(rst_n), .start(start), .ld_en(ld_en), .mem_rd(mem_rd),
  .busy(busy), .done(done), .ptr0(ptr0), .ptr1(ptr1));

// File: tb/ptr_indirect_unit_tb_top.sv
module ptr_indirect_unit_tb_top;
  logic clk = 0, rst_n = 0;
  logic start = 0, sel = 0, use_ofs = 0, ld_en = 0, ld_sel = 0;
  logic [1:0] mode = 0;
  logic [5:0] ofs_k = 0;
  logic [15:0] ld_val = 0, mem_addr, ptr0, ptr1;
  logic mem_rd, z_out, busy, done;
  logic [7:0] mem_rdata = 0, w_out;

  int nchk = 0, nbad = 0, npush = 0, ndone = 0;
  logic [15:0] m0 = 0, m1 = 0;

  typedef struct { logic [7:0] w; logic z; logic [15:0] p0, p1; string tag; } exp_t;
  exp_t q[$];

  always #5 clk = ~clk;

  ptr_indirect_unit dut_i (.*);

  function automatic logic [7:0] fn(logic [15:0] a);
    return a[7:0] ^ a[15:8];
  endfunction

  always_ff @(posedge clk) if (mem_rd) mem_rdata <= fn(mem_addr);

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  always @(negedge clk) if (rst_n && done) begin
    exp_t e;
    ndone++;
    if (q.size() == 0) chk("R12 extra done", 1, 0);
    else begin
      e = q.pop_front();
      chk({e.tag, " R9 w"}, w_out, e.w);
      chk({e.tag, " R9 z"}, z_out, e.z);
      chk({e.tag, " p0"}, ptr0, e.p0);
      chk({e.tag, " p1"}, ptr1, e.p1);
    end
  end

  task automatic op(string tag, logic s, logic uo, logic [1:0] md, logic [5:0] k,
                    logic hold_start = 0, logic ld_hit = 0, logic [15:0] lv = 0);
    logic [15:0] c, ea, nx;
    exp_t e;
    @(negedge clk);
    c = s ? m1 : m0;
    if (uo) begin ea = c + {{10{k[5]}}, k}; nx = c; end
    else case (md)
      2'b00: begin ea = c + 1; nx = c + 1; end
      2'b01: begin ea = c - 1; nx = c - 1; end
      2'b10: begin ea = c; nx = c + 1; end
      default: begin ea = c; nx = c - 1; end
    endcase
    if (ld_hit) nx = lv;
    start = 1; sel = s; use_ofs = uo; mode = md; ofs_k = k;
    #1 chk({tag, " addr"}, mem_addr, ea);
    chk({tag, " rd"}, mem_rd, 1);
    if (s) m1 = nx; else m0 = nx;
    e.w = fn(ea); e.z = (fn(ea) == 0); e.p0 = m0; e.p1 = m1; e.tag = tag;
    q.push_back(e); npush++;
    @(negedge clk);
    start = hold_start;
    if (ld_hit) begin ld_en = 1; ld_sel = s; ld_val = lv; end
    @(negedge clk);
    start = 0; ld_en = 0;
  endtask

  initial begin
    #200000;
    nbad++;
    $display("FAIL watchdog act=hang exp=finish");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nbad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 p0", ptr0, 0); chk("R1 p1", ptr1, 0); chk("R1 w", w_out, 0);
    chk("R1 z", z_out, 0); chk("R1 busy", busy, 0); chk("R1 done", done, 0);
    ld_en = 1; ld_sel = 0; ld_val = 16'h1234;
    @(negedge clk);
    ld_sel = 1; ld_val = 16'h5678;
    @(negedge clk);
    ld_en = 0; m0 = 16'h1234; m1 = 16'h5678;
    chk("R2 p0", ptr0, 16'h1234); chk("R2 p1", ptr1, 16'h5678);
    op("R3 preinc R10", 0, 0, 2'b00, 0);
    op("R4 predec", 1, 0, 2'b01, 0);
    op("R5 postinc", 0, 0, 2'b10, 0);
    op("R6 postdec", 1, 0, 2'b11, 0);
    op("R7 ofs+31", 0, 1, 2'b00, 6'd31);
    op("R7 ofs-32", 1, 1, 2'b11, 6'b100000);
    op("R7 ofs0", 0, 1, 2'b10, 0);
    @(negedge clk);
    ld_en = 1; ld_sel = 0; ld_val = 16'hFFFF;
    @(negedge clk);
    ld_sel = 1; ld_val = 16'h0000;
    @(negedge clk);
    ld_en = 0; m0 = 16'hFFFF; m1 = 0;
    op("R8 wrap preinc zero", 0, 0, 2'b00, 0);
    op("R8 wrap postdec", 1, 0, 2'b11, 0);
    op("R8 wrap predec", 0, 0, 2'b01, 0);
    op("R8 ofs wrap", 1, 1, 2'b00, 6'd2);
    op("R12 start held", 0, 0, 2'b10, 0, 1);
    op("R11 load wins", 1, 0, 2'b10, 0, 0, 1, 16'h1212);
    op("R9 zero byte", 1, 1, 2'b00, 0);
    repeat (4) @(negedge clk);
    chk("R12 done count", ndone, npush);
    chk("R10 idle p0", ptr0, m0);
    chk("R10 idle p1", ptr1, m1);
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nbad);
    $finish;
  end
endmodule